// File: doc/BRIEF.md
# Channel Interrupt Vector Encoder with Timers

This block collects the interrupt sources of one serial/timer channel and turns them into a single request line plus a restart opcode that the processor fetches during an interrupt-acknowledge cycle. There are eight sources. Five are internal down-counting timers. The other three are level inputs: an inverted sense line, receive-data-available and transmit-buffer-empty. A parallel-port bit 7 input shares the highest source position with timer 5.

Software writes an 8-bit mask, a command byte and five timer load bytes through a simple write port. The interrupt-pending output is the OR of every source that is both active and unmasked. The request line follows pending only while acknowledge is enabled in the command byte. An acknowledge strobe clears the latched request of the winning source. A built-in prescaler produces the tick on which all timers count.

Top module: `chan_irq_unit`

## Requirements
- R1: Write targets are selected by `wr_sel_i`: 0 mask, 1 command, 2 to 6 timers 1 to 5. Source positions, which are also the mask bits, are: bit0 timer 1, bit1 timer 2, bit2 sense (active when `sense_i` is low), bit3 timer 3, bit4 receive available, bit5 transmit empty, bit6 timer 4, bit7 timer 5 OR `par7_i`. `pend_o` is high exactly when some active source has its mask bit set.
- R2: The acknowledge code for source position p is 0xC7 + 8*p, so it runs from 0xC7 for timer 1 up to 0xFF for timer 5 / parallel.
- R3: When several unmasked sources are active, `vec_o` carries the code of the highest position.
- R4: When nothing is pending, `vec_o` is 0x00.
- R5: A timer loaded with N > 0 decrements once per prescaler tick. When it reaches zero it latches its request and stops; it does not request again until it is reloaded.
- R6: Writing zero to a timer stops it without raising a request.
- R7: A one-cycle `inta_i` while pending clears only the winner's latched timer request. Level sources keep their state.
- R8: A command write with bit 0 set clears all timer counts and all latched timer requests.
- R9: Command bit 2 is stored on every command write and appears on `rst7_o`.
- R10: `irq_o` equals `pend_o` gated by command bit 3 (acknowledge enable).
- R11: After reset the mask and command are zero, all timers are idle, and `pend_o`, `irq_o`, `rst7_o` and `vec_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write target select |
| wr_data_i | input | 8 | Write data |
| inta_i | input | 1 | Interrupt acknowledge strobe |
| sense_i | input | 1 | Sense line, source active when low |
| rda_i | input | 1 | Receive data available level |
| tbe_i | input | 1 | Transmit buffer empty level |
| par7_i | input | 1 | Parallel input bit 7, shares position 7 |
| vec_o | output | 8 | Restart opcode of the winning source |
| pend_o | output | 1 | Interrupt pending |
| irq_o | output | 1 | Interrupt request to the processor |
| rst7_o | output | 1 | Stored restart-7 mode bit |

## Verification
The level sources are driven through a table of mask and input combinations. Some rows have one source active, which checks its code and mask position. Some have two or more active, which separates highest-code priority from mask-order selection. Rows with the active sources masked off show that masking and the idle 0x00 code work. Timers are then tested directly: pairs that expire together check acknowledge-by-acknowledge unwinding, a zero write mid-count checks the disable, a long wait after expiry checks that the timer stops, and a reset command issued while requests are latched checks the clear.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  localparam int NSRC = 8;
  localparam int NTMR = 5;
  localparam int DW   = 8;
  localparam int SW   = $clog2(NSRC);

  typedef enum logic [2:0] {
    SEL_MASK = 3'd0,
    SEL_CMD  = 3'd1,
    SEL_TMR1 = 3'd2,
    SEL_TMR2 = 3'd3,
    SEL_TMR3 = 3'd4,
    SEL_TMR4 = 3'd5,
    SEL_TMR5 = 3'd6
  } reg_sel_e;

  localparam int CMD_CLR   = 0;
  localparam int CMD_RST7  = 2;
  localparam int CMD_ACKEN = 3;

  // source position of each timer
  function automatic logic [SW-1:0] tmr_src(input int t);
    case (t)
      0:       return SW'(0);
      1:       return SW'(1);
      2:       return SW'(3);
      3:       return SW'(6);
      default: return SW'(7);
    endcase
  endfunction

  function automatic logic [DW-1:0] rst_code(input logic [SW-1:0] idx);
    return {2'b11, idx, 3'b111};
  endfunction
endpackage

// File: rtl/chan_irq_prescale.sv
module chan_irq_prescale #(
  parameter int PRESCALE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(PRESCALE);
      localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/chan_irq_timer.sv
module chan_irq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic         ack_i,
  output logic         req_o
);
  logic [W-1:0] cnt_q;
  logic         expire;

  assign expire = !load_i && tick_i && (cnt_q == W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      req_o <= 1'b0;
    end else begin
      if (load_i)                     cnt_q <= load_val_i;
      else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      // a fresh expiry wins over a same-cycle acknowledge
      if (expire)     req_o <= 1'b1;
      else if (ack_i) req_o <= 1'b0;
    end
  end
endmodule

// File: rtl/chan_irq_prio.sv
module chan_irq_prio
  import chan_irq_pkg::*;
(
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] mask_i,
  output logic            pend_o,
  output logic [SW-1:0]   win_o,
  output logic [DW-1:0]   vec_o
);
  logic [NSRC-1:0] act;

  assign act    = src_i & mask_i;
  assign pend_o = |act;

  always_comb begin
    win_o = '0;
    for (int i = 0; i < NSRC; i++)
      if (act[i]) win_o = SW'(i);
  end

  assign vec_o = pend_o ? rst_code(win_o) : '0;
endmodule

// File: rtl/chan_irq_unit.sv
module chan_irq_unit
  import chan_irq_pkg::*;
#(
  parameter int PRESCALE = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          inta_i,
  input  logic          sense_i,
  input  logic          rda_i,
  input  logic          tbe_i,
  input  logic          par7_i,
  output logic [DW-1:0] vec_o,
  output logic          pend_o,
  output logic          irq_o,
  output logic          rst7_o
);
  logic [DW-1:0]   mask_q;
  logic            acken_q;
  logic            rst7_q;
  logic            tick;
  logic            cmd_wr, cmd_clr;
  logic [NTMR-1:0] t_req;
  logic [NSRC-1:0] src;
  logic [SW-1:0]   win;
  logic            ack_hit;

  assign cmd_wr  = wr_en_i && (wr_sel_i == SEL_CMD);
  assign cmd_clr = cmd_wr && wr_data_i[CMD_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      acken_q <= 1'b0;
      rst7_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_MASK) mask_q <= wr_data_i;
      if (cmd_wr) begin
        acken_q <= wr_data_i[CMD_ACKEN];
        rst7_q  <= wr_data_i[CMD_RST7];
      end
    end
  end

  chan_irq_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  assign ack_hit = inta_i && pend_o;

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    localparam logic [SW-1:0] SIDX = tmr_src(g);
    chan_irq_timer #(.W(DW)) u_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (wr_en_i && (wr_sel_i == 3'(SEL_TMR1 + g))),
      .load_val_i (wr_data_i),
      .clr_i      (cmd_clr),
      .tick_i     (tick),
      .ack_i      (ack_hit && (win == SIDX)),
      .req_o      (t_req[g])
    );
  end

  assign src = {t_req[4] | par7_i, t_req[3], tbe_i, rda_i,
                t_req[2], ~sense_i, t_req[1], t_req[0]};

  chan_irq_prio u_prio (
    .src_i  (src),
    .mask_i (mask_q),
    .pend_o (pend_o),
    .win_o  (win),
    .vec_o  (vec_o)
  );

  assign irq_o  = pend_o && acken_q;
  assign rst7_o = rst7_q;
endmodule

// File: rtl/chan_irq_chk.sv
module chan_irq_chk
  import chan_irq_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [2:0]    wr_sel_i,
  input logic [DW-1:0] wr_data_i,
  input logic [DW-1:0] vec_o,
  input logic          pend_o,
  input logic          irq_o,
  input logic          rst7_o,
  input logic [NTMR-1:0] t_req
);
  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_o);

  // R4
  idle_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_o |-> vec_o == '0);

  // R2
  vec_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> (vec_o[2:0] == 3'b111 && vec_o[7:6] == 2'b11));

  // R9
  rst7_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_CMD) |=> rst7_o == $past(wr_data_i[CMD_RST7]));

  // R8
  cmd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_CMD && wr_data_i[CMD_CLR]) |=> t_req == '0);
endmodule

bind chan_irq_unit chan_irq_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
  .vec_o, .pend_o, .irq_o, .rst7_o, .t_req(t_req)
);

// File: tb/chan_irq_unit_test.sv
module chan_irq_unit_test;
  localparam int P = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       inta_i = 1'b0;
  logic       sense_i = 1'b1;
  logic       rda_i = 1'b0;
  logic       tbe_i = 1'b0;
  logic       par7_i = 1'b0;
  logic [7:0] vec_o;
  logic       pend_o, irq_o, rst7_o;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  chan_irq_unit #(.PRESCALE(P)) uut (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .inta_i,
    .sense_i, .rda_i, .tbe_i, .par7_i, .vec_o, .pend_o, .irq_o, .rst7_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk_i);
    inta_i = 1'b1;
    @(negedge clk_i);
    inta_i = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // {mask, sense_i, rda, tbe, par7, pend, vec}
  localparam int NV = 10;
  localparam logic [20:0] TBL [NV] = '{
    {8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hE7},
    {8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hEF},
    {8'hDF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hE7},
    {8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hD7},
    {8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hE7},
    {8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF},
    {8'h7F, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    {8'h04, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hD7},
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00}
  };

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(3);
    // R11 reset state
    chk("R11 pend", pend_o, 0);
    chk("R11 irq", irq_o, 0);
    chk("R11 vec", vec_o, 8'h00);
    chk("R11 rst7", rst7_o, 0);
    rst_ni = 1'b1;
    wait_cyc(2);
    rda_i = 1'b1;
    @(negedge clk_i);
    chk("R11 mask zero after reset", pend_o, 0);
    rda_i = 1'b0;

    // R1 R2 R3 R4 level-source table
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, TBL[i][20:13]);
      sense_i = TBL[i][12]; rda_i = TBL[i][11];
      tbe_i = TBL[i][10];   par7_i = TBL[i][9];
      @(negedge clk_i);
      chk($sformatf("R1 pend row %0d", i), pend_o, TBL[i][8]);
      chk($sformatf("R3 vec row %0d", i), vec_o, TBL[i][7:0]);
    end
    sense_i = 1'b1; rda_i = 1'b0; tbe_i = 1'b0; par7_i = 1'b0;

    // R5 timer 1 expiry
    wr(3'd0, 8'h01);
    wr(3'd2, 8'd3);
    wait_cyc(2 * P - 1);
    chk("R5 t1 not yet", pend_o, 0);
    wait_cyc(2 * P + 2);
    chk("R5 t1 expired", pend_o, 1);
    chk("R2 t1 code", vec_o, 8'hC7);

    // R10 gating, R9 rst7 storage
    chk("R10 irq off", irq_o, 0);
    wr(3'd1, 8'h0C);
    chk("R10 irq on", irq_o, 1);
    chk("R9 rst7 set", rst7_o, 1);
    wr(3'd1, 8'h08);
    chk("R9 rst7 cleared", rst7_o, 0);

    // R7 ack clears, R5 stays stopped
    ack();
    chk("R7 ack clears t1", pend_o, 0);
    chk("R4 idle vec", vec_o, 8'h00);
    wait_cyc(10 * P);
    chk("R5 t1 stopped", pend_o, 0);

    // R3 R7 two timers unwound one ack at a time
    wr(3'd0, 8'hFF);
    wr(3'd3, 8'd2);
    wr(3'd5, 8'd2);
    wait_cyc(5 * P);
    chk("R3 t4 over t2", vec_o, 8'hF7);
    ack();
    chk("R7 t2 left", vec_o, 8'hCF);
    ack();
    chk("R7 all cleared", pend_o, 0);

    // R7 ack of a level winner leaves timer latch alone
    wr(3'd2, 8'd1);
    wait_cyc(2 * P);
    rda_i = 1'b1;
    @(negedge clk_i);
    chk("R3 rda over t1", vec_o, 8'hE7);
    ack();
    chk("R7 level kept", vec_o, 8'hE7);
    rda_i = 1'b0;
    @(negedge clk_i);
    chk("R7 t1 still latched", vec_o, 8'hC7);
    ack();
    chk("R7 t1 acked", pend_o, 0);

    // R6 zero write disables
    wr(3'd4, 8'd200);
    wait_cyc(3 * P);
    wr(3'd4, 8'd0);
    wait_cyc(300 * P);
    chk("R6 t3 disabled", pend_o, 0);
    wr(3'd6, 8'd0);
    wait_cyc(4 * P);
    chk("R6 zero load no request", pend_o, 0);

    // R8 command reset
    wr(3'd2, 8'd2);
    wr(3'd6, 8'd60);
    wait_cyc(4 * P);
    chk("R8 t1 pending before clear", pend_o, 1);
    wr(3'd1, 8'h09);
    chk("R8 pend cleared", pend_o, 0);
    chk("R8 irq cleared", irq_o, 0);
    wait_cyc(80 * P);
    chk("R8 t5 count cleared", pend_o, 0);

    // R1 par7 shares position 7 with timer 5
    wr(3'd6, 8'd1);
    wait_cyc(2 * P);
    chk("R2 t5 code", vec_o, 8'hFF);
    ack();
    chk("R7 t5 acked", pend_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule